// File: doc/BRIEF.md
# DMA Address Gate and Word Splitter

This block sits between a DMA engine and the memory bus. Each DMA request names an address, a width (byte or 16-bit word), a direction and write data. The block turns it into one or two memory accesses, returns the read data and reports the total number of wait states the memory side took.

An 8-bit control register is written and read over a simple I/O port. Bit 2 of this register limits the reach of DMA. When the bit is set, every address sent to memory has bit 20 and all higher bits forced to zero, so DMA stays inside the low megabyte. When the bit is clear, the full address passes through.

A word request at an even address goes out as one word access. A word request at an odd address cannot be issued as one aligned access, so it becomes two byte accesses: the lower byte at the given address, then the upper byte at the next address. Each of the two addresses is limited on its own, and the two wait counts are added together. The register comes out of reset as FEh on standard-resolution builds (parameter `HIRES` = 0) and as FBh on high-resolution builds (`HIRES` = 1).

Top module: `dma_a20_gate`

## Requirements
- R1: After reset, the control register reads FEh when `HIRES` is 0 and FBh when `HIRES` is 1.
- R2: A read of the control register returns all eight bits of the last value written, from the cycle after the write onward.
- R3: While control bit 2 is 1, every memory access drives `mem_addr` bits 20 and above as zero, and bits 19:0 equal the corresponding bits of the request's address.
- R4: While control bit 2 is 0, the memory address equals the request's address with no bits changed.
- R5: A byte request (`dma_word` = 0) makes exactly one byte access (`mem_word` = 0). Read data comes back on `dma_rdata[7:0]` with `dma_rdata[15:8]` = 0. `dma_wait` equals that access's wait.
- R6: A word request at an even address makes exactly one word access (`mem_word` = 1) carrying all 16 data bits in either direction. `dma_wait` equals that access's wait.
- R7: A word request at an odd address A makes two byte accesses in order: first at A, then at A+1, wrapping modulo 2^ADDR_W. For a read, the first byte is placed in `dma_rdata[7:0]` and the second in `dma_rdata[15:8]`.
- R8: For a split write, the first byte access carries `dma_wdata[7:0]` on `mem_wdata[7:0]`, and the second carries `dma_wdata[15:8]` on `mem_wdata[7:0]`.
- R9: For a split request, `dma_wait` equals the sum of the two byte-access waits.
- R10: The limit is applied to each byte of a split access on its own. With bit 2 set, an odd word at 0FFFFFh sends its second byte to address 0.
- R11: `dma_done` is a one-cycle pulse. With a memory that answers in the same cycle, it rises one cycle after the start for a single access and two cycles after the start for a split. No memory request is active while `dma_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr_en | input | 1 | Write strobe for the control register |
| io_wdata | input | 8 | Control register write value |
| io_rdata | output | 8 | Control register readback |
| dma_start | input | 1 | Starts a request; accepted when idle |
| dma_addr | input | ADDR_W | Request address |
| dma_word | input | 1 | 1 = 16-bit request, 0 = byte |
| dma_write | input | 1 | 1 = write, 0 = read |
| dma_wdata | input | 16 | Write data (byte requests use bits 7:0) |
| dma_done | output | 1 | One-cycle completion pulse |
| dma_rdata | output | 16 | Assembled read data |
| dma_wait | output | WAIT_W+1 | Total wait count of the request |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_addr | output | ADDR_W | Limited memory address |
| mem_word | output | 1 | 1 = word access, 0 = byte access |
| mem_write | output | 1 | Access direction |
| mem_wdata | output | 16 | Access write data (byte accesses use bits 7:0) |
| mem_ack | input | 1 | Memory acknowledges the current access |
| mem_rdata | input | 16 | Memory read data (byte accesses return bits 7:0) |
| mem_wait | input | WAIT_W | Wait count of the acknowledged access |

## Verification
Requests are tried as bytes, even words and odd words, each as both reads and writes, with the limit bit both set and clear. This separates the single-access path from the split path and shows whether masking is skipped or applied. The memory model returns data and wait counts that depend on the address, and byte reads carry junk in the upper half. A swapped byte lane, a wrong second address, a dropped wait term or leaked upper data each produce a different value. Directed cases place odd words at 0FFFFFh (limit set and clear) and at the top of the address space to separate per-byte limiting from wraparound. Register writes of all zeros, all ones and mixed patterns cover readback.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;

    // Bit of the control register that confines DMA to the low megabyte
    localparam int GATE_BIT   = 2;
    // Number of address bits that survive while confinement is active
    localparam int LOW_SPAN_W = 20;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_e;

    function automatic logic [7:0] ctrl_reset_value(input bit hires);
        return hires ? 8'hFB : 8'hFE;
    endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg #(
    parameter bit HIRES = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] ctrl_q
);
    localparam logic [7:0] RST_VAL = dma_gate_pkg::ctrl_reset_value(HIRES);

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= RST_VAL;
        else if (wr_en) ctrl_q <= wdata;
    end
endmodule

// File: rtl/dma_addr_limiter.sv
module dma_addr_limiter #(
    parameter int ADDR_W = 24,
    parameter int LOW_W  = 20
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              confine,
    output logic [ADDR_W-1:0] addr_out
);
    generate
        if (ADDR_W > LOW_W) begin : g_cut
            always_comb begin
                if (confine) addr_out = {{(ADDR_W-LOW_W){1'b0}}, addr_in[LOW_W-1:0]};
                else         addr_out = addr_in;
            end
        end else begin : g_pass
            logic unused_confine;
            assign unused_confine = confine;
            assign addr_out = addr_in;
        end
    endgenerate
endmodule

// File: rtl/dma_split_seq.sv
module dma_split_seq
    import dma_gate_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    input  logic [WAIT_W-1:0] mem_wait,
    output logic [ADDR_W-1:0] raw_addr,
    output logic              mem_req,
    output logic              mem_word,
    output logic              mem_write,
    output logic [15:0]       mem_wdata,
    output logic              done,
    output logic [15:0]       rdata,
    output logic [WAIT_W:0]   wait_sum
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              write;
        logic              split;
        logic [15:0]       wdata;
    } req_t;

    seq_state_e state_q;
    req_t       req_q;
    logic [15:0]     rdata_q;
    logic [WAIT_W:0] wait_q;
    logic            done_q;

    always_comb begin
        mem_req   = (state_q != SEQ_IDLE);
        mem_word  = (state_q == SEQ_FIRST) && req_q.word && !req_q.split;
        mem_write = mem_req && req_q.write;
        raw_addr  = (state_q == SEQ_SECOND) ? (req_q.addr + ADDR_W'(1)) : req_q.addr;
        if (state_q == SEQ_SECOND) mem_wdata = {8'h00, req_q.wdata[15:8]};
        else if (mem_word)         mem_wdata = req_q.wdata;
        else                       mem_wdata = {8'h00, req_q.wdata[7:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            req_q   <= '0;
            rdata_q <= '0;
            wait_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        req_q.addr  <= req_addr;
                        req_q.word  <= req_word;
                        req_q.write <= req_write;
                        req_q.split <= req_word && req_addr[0];
                        req_q.wdata <= req_wdata;
                        state_q     <= SEQ_FIRST;
                    end
                end
                SEQ_FIRST: begin
                    if (mem_ack) begin
                        wait_q  <= {1'b0, mem_wait};
                        rdata_q <= mem_word ? mem_rdata : {8'h00, mem_rdata[7:0]};
                        if (req_q.split) begin
                            state_q <= SEQ_SECOND;
                        end else begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                SEQ_SECOND: begin
                    if (mem_ack) begin
                        rdata_q[15:8] <= mem_rdata[7:0];
                        wait_q        <= wait_q + {1'b0, mem_wait};
                        state_q       <= SEQ_IDLE;
                        done_q        <= 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign rdata    = rdata_q;
    assign wait_sum = wait_q;
endmodule

// File: rtl/dma_a20_gate.sv
module dma_a20_gate #(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 6,
    parameter bit HIRES  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr_en,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              dma_start,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_word,
    input  logic              dma_write,
    input  logic [15:0]       dma_wdata,
    output logic              dma_done,
    output logic [15:0]       dma_rdata,
    output logic [WAIT_W:0]   dma_wait,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_word,
    output logic              mem_write,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    input  logic [WAIT_W-1:0] mem_wait
);
    localparam int LOW_W = dma_gate_pkg::LOW_SPAN_W;

    logic [7:0]        ctrl_q;
    logic [ADDR_W-1:0] raw_addr;

    dma_ctrl_reg #(.HIRES(HIRES)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (io_wr_en),
        .wdata (io_wdata),
        .ctrl_q(ctrl_q)
    );

    dma_split_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (dma_start),
        .req_addr (dma_addr),
        .req_word (dma_word),
        .req_write(dma_write),
        .req_wdata(dma_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .mem_wait (mem_wait),
        .raw_addr (raw_addr),
        .mem_req  (mem_req),
        .mem_word (mem_word),
        .mem_write(mem_write),
        .mem_wdata(mem_wdata),
        .done     (dma_done),
        .rdata    (dma_rdata),
        .wait_sum (dma_wait)
    );

    dma_addr_limiter #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_lim (
        .addr_in (raw_addr),
        .confine (ctrl_q[dma_gate_pkg::GATE_BIT]),
        .addr_out(mem_addr)
    );

    assign io_rdata = ctrl_q;
endmodule

// File: rtl/dma_a20_gate_chk.sv
module dma_a20_gate_chk #(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 6,
    parameter bit HIRES  = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              io_wr_en,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              dma_done,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_word,
    input logic              mem_ack
);
    localparam int         LOW_W   = dma_gate_pkg::LOW_SPAN_W;
    localparam logic [7:0] RST_VAL = dma_gate_pkg::ctrl_reset_value(HIRES);

    // R1: value right after reset
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> io_rdata == RST_VAL);

    // R2: readback follows the last write
    assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(io_wr_en) && !$past(rst)) |-> io_rdata == $past(io_wdata));

    // R3: confined accesses never reach above the low megabyte
    assert_confined_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && io_rdata[dma_gate_pkg::GATE_BIT]) |-> (mem_addr >> LOW_W) == '0);

    // R6, R7: word accesses are always aligned
    assert_word_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_word) |-> !mem_addr[0]);

    // R11: no request outstanding while completion is reported
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        dma_done |-> !mem_req);

    // R11: an unacknowledged access holds its address
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind dma_a20_gate dma_a20_gate_chk #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .HIRES(HIRES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .io_wr_en(io_wr_en),
    .io_wdata(io_wdata),
    .io_rdata(io_rdata),
    .dma_done(dma_done),
    .mem_req (mem_req),
    .mem_addr(mem_addr),
    .mem_word(mem_word),
    .mem_ack (mem_ack)
);

// File: tb/dma_a20_gate_tb.sv
`timescale 1ns/1ps
module dma_a20_gate_tb;
    localparam int ADDR_W = 24;
    localparam int WAIT_W = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              io_wr_en = 1'b0;
    logic [7:0]        io_wdata = '0;
    logic [7:0]        io_rdata;
    logic              dma_start = 1'b0;
    logic [ADDR_W-1:0] dma_addr = '0;
    logic              dma_word = 1'b0;
    logic              dma_write = 1'b0;
    logic [15:0]       dma_wdata = '0;
    logic              dma_done;
    logic [15:0]       dma_rdata;
    logic [WAIT_W:0]   dma_wait;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_word;
    logic              mem_write;
    logic [15:0]       mem_wdata;
    logic              mem_ack;
    logic [15:0]       mem_rdata;
    logic [WAIT_W-1:0] mem_wait;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] ctrl_model;

    logic [ADDR_W-1:0] acc_addr  [4];
    logic              acc_word  [4];
    logic              acc_write [4];
    logic [15:0]       acc_wdata [4];
    int                n_acc = 0;

    always #2.5 clk = ~clk;

    dma_a20_gate #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .HIRES(1'b0)) u_dut (
        .clk(clk), .rst(rst),
        .io_wr_en(io_wr_en), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dma_start(dma_start), .dma_addr(dma_addr), .dma_word(dma_word),
        .dma_write(dma_write), .dma_wdata(dma_wdata),
        .dma_done(dma_done), .dma_rdata(dma_rdata), .dma_wait(dma_wait),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_word(mem_word),
        .mem_write(mem_write), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_wait(mem_wait)
    );

    function automatic logic [7:0] mbyte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
    endfunction

    function automatic logic [WAIT_W-1:0] mwait(input logic [ADDR_W-1:0] a);
        return WAIT_W'(a[4:0]) + WAIT_W'(1);
    endfunction

    function automatic logic [ADDR_W-1:0] limit(input logic [ADDR_W-1:0] a, input logic g);
        return g ? (a & 24'h0FFFFF) : a;
    endfunction

    // Memory model: answers in the same cycle
    assign mem_ack = mem_req;
    always_comb begin
        if (mem_word) mem_rdata = {mbyte(mem_addr + 24'd1), mbyte(mem_addr)};
        else          mem_rdata = {8'hEE, mbyte(mem_addr)};
        mem_wait = mwait(mem_addr);
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack && n_acc < 4) begin
            acc_addr[n_acc]  = mem_addr;
            acc_word[n_acc]  = mem_word;
            acc_write[n_acc] = mem_write;
            acc_wdata[n_acc] = mem_wdata;
            n_acc = n_acc + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] v);
        @(negedge clk);
        io_wr_en = 1'b1;
        io_wdata = v;
        @(negedge clk);
        io_wr_en = 1'b0;
        ctrl_model = v;
        chk(io_rdata == v, "R2 readback", 32'(io_rdata), 32'(v));
    endtask

    task automatic run_txn(input logic [ADDR_W-1:0] a, input logic w, input logic wr,
                           input logic [15:0] wd);
        logic split, g;
        logic [ADDR_W-1:0] a0, a1;
        logic [15:0] exp_rd;
        logic [WAIT_W:0] exp_wait;
        int cnt;
        g     = ctrl_model[2];
        split = w && a[0];
        a0    = limit(a, g);
        a1    = limit(a + 24'd1, g);
        @(negedge clk);
        n_acc = 0;
        dma_start = 1'b1; dma_addr = a; dma_word = w; dma_write = wr; dma_wdata = wd;
        @(negedge clk);
        dma_start = 1'b0;
        cnt = 0;
        while (!dma_done && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == (split ? 2 : 1), "R11 done latency", 32'(cnt), split ? 32'd2 : 32'd1);
        chk(n_acc == (split ? 2 : 1), split ? "R7 access count" : "R6 access count",
            32'(n_acc), split ? 32'd2 : 32'd1);
        chk(acc_addr[0] == a0, g ? "R3 first address" : "R4 first address",
            32'(acc_addr[0]), 32'(a0));
        chk(acc_word[0] == (w && !split), w ? "R6 access width" : "R5 access width",
            32'(acc_word[0]), 32'(w && !split));
        chk(acc_write[0] == wr, "R5 direction", 32'(acc_write[0]), 32'(wr));
        if (split) begin
            chk(acc_addr[1] == a1, "R10 second address", 32'(acc_addr[1]), 32'(a1));
            chk(acc_word[1] == 1'b0, "R7 second width", 32'(acc_word[1]), 32'd0);
        end
        if (wr) begin
            if (split) begin
                chk(acc_wdata[0][7:0] == wd[7:0], "R8 first byte", 32'(acc_wdata[0][7:0]), 32'(wd[7:0]));
                chk(acc_wdata[1][7:0] == wd[15:8], "R8 second byte", 32'(acc_wdata[1][7:0]), 32'(wd[15:8]));
            end else if (w) begin
                chk(acc_wdata[0] == wd, "R6 word write", 32'(acc_wdata[0]), 32'(wd));
            end else begin
                chk(acc_wdata[0][7:0] == wd[7:0], "R5 byte write", 32'(acc_wdata[0][7:0]), 32'(wd[7:0]));
            end
        end else begin
            if (split)  exp_rd = {mbyte(a1), mbyte(a0)};
            else if (w) exp_rd = {mbyte(a0 + 24'd1), mbyte(a0)};
            else        exp_rd = {8'h00, mbyte(a0)};
            chk(dma_rdata == exp_rd, split ? "R7 read assembly" : (w ? "R6 word read" : "R5 byte read"),
                32'(dma_rdata), 32'(exp_rd));
        end
        exp_wait = split ? ({1'b0, mwait(a0)} + {1'b0, mwait(a1)}) : {1'b0, mwait(a0)};
        chk(dma_wait == exp_wait, split ? "R9 wait sum" : "R5 R6 wait",
            32'(dma_wait), 32'(exp_wait));
        @(negedge clk);
        chk(dma_done == 1'b0, "R11 done pulse", 32'(dma_done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(io_rdata == 8'hFE, "R1 reset value", 32'(io_rdata), 32'hFE);
        ctrl_model = 8'hFE;

        // Directed: limit on (reset value has bit 2 set)
        run_txn(24'hABCDEF, 1'b0, 1'b0, 16'h0000);   // R3 byte read
        run_txn(24'h0FFFFF, 1'b1, 1'b0, 16'h0000);   // R10 split crossing 1 MB
        run_txn(24'h3FFFFF, 1'b1, 1'b1, 16'hBEEF);   // R8 R10 split write
        run_txn(24'h012344, 1'b1, 1'b0, 16'h0000);   // R6 even word read

        io_write(8'h00);
        io_write(8'hFF);
        io_write(8'hA5);
        io_write(8'h00);                              // limit off

        run_txn(24'h0FFFFF, 1'b1, 1'b0, 16'h0000);   // R4 second byte at 100000h
        run_txn(24'hFFFFFF, 1'b1, 1'b0, 16'h0000);   // R7 wrap at top
        run_txn(24'h800002, 1'b1, 1'b1, 16'hC0DE);   // R6 even word write
        run_txn(24'hC00001, 1'b0, 1'b1, 16'h12AB);   // R5 byte write

        for (int i = 0; i < 120; i++) begin
            if (i % 15 == 0) io_write(8'($urandom));
            run_txn(24'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule